// File: doc/BRIEF.md
# SPI Slave Command Buffer Controller

This block lets an external SPI master exchange data with an on-chip host through a small command protocol. Each SPI frame opens with an 8-bit opcode, then an 8-bit address byte, then a payload whose length depends on the opcode. The slave decodes the opcode and does one of four things. It captures a 32-byte payload into a receive buffer. It shifts a 32-byte transmit buffer out on MISO. It loads its 8-bit status register from the master. It returns that status register to the master.

The SPI pins are brought into the system clock domain through two-flop synchronizers and sampled there. A configuration bit selects which SCLK edge samples MOSI. MISO changes on the other edge. When a frame completes, a done flag for its opcode is set together with a general transaction flag. The host reaches the buffers, the status register, the flags, their enables and the edge select through a word-wide register port. The interrupt output is the OR of the enabled, set flags.

Top module: `spis_cmdbuf`

## Requirements
- R1: After reset, every host register reads zero, `irq` is low and `miso` is low.
- R2: Opcode 0x02 followed by 256 payload bits stores the payload in the receive words (host addresses 0..7). The first payload byte lands in bits 31:24 of word 0, and each byte is sent MSB first.
- R3: Opcode 0x03 shifts out 32 bytes, each MSB first. Byte k is taken from transmit word k/4 (host address 8+k/4), bits 8*(k%4)+7 down to 8*(k%4). The receive words are left unchanged.
- R4: Opcode 0x01 loads the status register (host address 16, bits 7:0) from the 8 payload bits. Opcode 0x04 returns the status register MSB first.
- R5: A frame that delivers its full payload sets its own flag in the flag register (host address 17). The flag bits are: bit 0 for 0x02, bit 1 for 0x03, bit 2 for 0x01, bit 3 for 0x04. The same frame also sets bit 4, the transaction-done flag.
- R6: `irq` is high exactly when some flag bit is set and its enable bit is set. The enables are bits 4:0 of the control register (host address 18), in the same bit order as the flags.
- R7: A host write to the flag register clears each flag whose written bit is 1. If a flag is set in the same cycle, the set wins.
- R8: Control bit 8 selects the MOSI sample edge: 1 selects rising SCLK, 0 selects falling SCLK. MISO is updated on the opposite edge.
- R9: Raising `cs_n` abandons any partial frame. A frame cut short sets no flag and commits no buffer or status contents, and the next frame is decoded from its first bit.
- R10: Any opcode other than 0x01..0x04 has no effect on buffers, status or flags, and MISO stays low for the whole frame.
- R11: The value of the address byte has no effect on any opcode.
- R12: MISO is low during the opcode and address phases and while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from the master |
| miso | output | 1 | SPI data to the master |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 5 | Host register word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr`, combinational |
| irq | output | 1 | Interrupt: OR of the enabled, set flags |

## Verification
The assertions assume that every SCLK level lasts long enough for the synchronizers to see it, so that each SCLK edge appears as exactly one sampled transition. They also assume that SCLK idles low while `cs_n` changes. The bench keeps to these limits by holding each SCLK half period at eight system clocks. It drives `cs_n` only while SCLK is low, and it leaves several idle clocks between frames. Host writes to the flag register happen only between frames, so no done event collides with a clear.

// File: rtl/spis_pkg.sv
`timescale 1ns/1ps
package spis_pkg;
    localparam int CMD_W = 8;
    localparam logic [CMD_W-1:0] OP_WR_STA = 8'h01;
    localparam logic [CMD_W-1:0] OP_WR_BUF = 8'h02;
    localparam logic [CMD_W-1:0] OP_RD_BUF = 8'h03;
    localparam logic [CMD_W-1:0] OP_RD_STA = 8'h04;
    localparam int EV_WBUF  = 0;
    localparam int EV_RBUF  = 1;
    localparam int EV_WSTA  = 2;
    localparam int EV_RSTA  = 3;
    localparam int EV_TRANS = 4;
    localparam int EV_N     = 5;
endpackage

// File: rtl/spis_sync.sv
`timescale 1ns/1ps
module spis_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sy_t;
    sy_t sy_q, sy_d;

    always_comb begin
        sy_d.s1 = d;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '{s1: INIT, s2: INIT};
        else        sy_q <= sy_d;
    end

    assign q = sy_q.s2;
endmodule

// File: rtl/spis_frame.sv
`timescale 1ns/1ps
module spis_frame import spis_pkg::*; #(
    parameter int BUF_BITS = 256,
    parameter int STA_W    = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_s,
    input  logic                cs_n_s,
    input  logic                mosi_s,
    input  logic                edge_rise,
    input  logic [BUF_BITS-1:0] tx_flat,
    input  logic [STA_W-1:0]    status,
    output logic                miso,
    output logic                rx_commit,
    output logic [BUF_BITS-1:0] rx_data,
    output logic                sta_commit,
    output logic [STA_W-1:0]    sta_data,
    output logic [EV_N-1:0]     done_evt
);
    localparam int HDR   = CMD_W + ADDR_W;
    localparam int FULL  = HDR + BUF_BITS;
    localparam int CNT_W = $clog2(FULL + 1);
    localparam int IDX_W = $clog2(BUF_BITS);
    localparam int SW    = $clog2(STA_W);

    typedef struct packed {
        logic                sclk_prev;
        logic [CNT_W-1:0]    cnt;
        logic [CMD_W-1:0]    cmd;
        logic [BUF_BITS-2:0] stage;
        logic                miso;
    } fr_t;
    fr_t f_q, f_d;

    logic             samp, shft, any_done;
    logic [CNT_W-1:0] pay_idx;
    logic [IDX_W-1:0] tx_idx;
    logic [SW-1:0]    sidx;

    always_comb begin
        samp = edge_rise ? (sclk_s & ~f_q.sclk_prev) : (~sclk_s & f_q.sclk_prev);
        shft = edge_rise ? (~sclk_s & f_q.sclk_prev) : (sclk_s & ~f_q.sclk_prev);
        pay_idx = f_q.cnt - CNT_W'(HDR);
        // bytes leave lowest lane first, bits MSB first within each byte
        tx_idx = {pay_idx[IDX_W-1:3], ~pay_idx[2:0]};
        sidx   = ~pay_idx[SW-1:0];

        f_d = f_q;
        f_d.sclk_prev = sclk_s;
        done_evt   = '0;
        rx_commit  = 1'b0;
        sta_commit = 1'b0;
        any_done   = 1'b0;
        rx_data  = {f_q.stage, mosi_s};
        sta_data = {f_q.stage[STA_W-2:0], mosi_s};

        if (cs_n_s) begin
            f_d.cnt  = '0;
            f_d.cmd  = '0;
            f_d.miso = 1'b0;
        end else begin
            if (samp) begin
                if (f_q.cnt != CNT_W'(FULL)) f_d.cnt = f_q.cnt + 1'b1;
                if (f_q.cnt < CNT_W'(CMD_W)) f_d.cmd = {f_q.cmd[CMD_W-2:0], mosi_s};
                f_d.stage = {f_q.stage[BUF_BITS-3:0], mosi_s};
                if (f_q.cnt == CNT_W'(FULL - 1)) begin
                    if (f_q.cmd == OP_WR_BUF) begin
                        rx_commit = 1'b1;
                        done_evt[EV_WBUF] = 1'b1;
                        any_done = 1'b1;
                    end
                    if (f_q.cmd == OP_RD_BUF) begin
                        done_evt[EV_RBUF] = 1'b1;
                        any_done = 1'b1;
                    end
                end
                if (f_q.cnt == CNT_W'(HDR + STA_W - 1)) begin
                    if (f_q.cmd == OP_WR_STA) begin
                        sta_commit = 1'b1;
                        done_evt[EV_WSTA] = 1'b1;
                        any_done = 1'b1;
                    end
                    if (f_q.cmd == OP_RD_STA) begin
                        done_evt[EV_RSTA] = 1'b1;
                        any_done = 1'b1;
                    end
                end
                done_evt[EV_TRANS] = any_done;
            end
            if (shft) begin
                f_d.miso = 1'b0;
                if (f_q.cnt >= CNT_W'(HDR)) begin
                    if (f_q.cmd == OP_RD_BUF && pay_idx < CNT_W'(BUF_BITS))
                        f_d.miso = tx_flat[tx_idx];
                    if (f_q.cmd == OP_RD_STA && pay_idx < CNT_W'(STA_W))
                        f_d.miso = status[sidx];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign miso = f_q.miso;

    // R9
    cs_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (f_q.cnt == '0));

    // R12
    hdr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.cnt < CNT_W'(HDR)) |-> !f_q.miso);

    // R10
    unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_q.cnt >= CNT_W'(HDR)) && f_q.cmd != OP_RD_BUF && f_q.cmd != OP_RD_STA) |-> !f_q.miso);
endmodule

// File: rtl/spis_regs.sv
`timescale 1ns/1ps
module spis_regs import spis_pkg::*; #(
    parameter int BUF_WORDS = 8,
    parameter int WORD_W    = 32,
    parameter int STA_W     = 8,
    parameter int REG_AW    = 5,
    localparam int BUF_BITS = BUF_WORDS * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [REG_AW-1:0]   host_addr,
    input  logic [WORD_W-1:0]   host_wdata,
    output logic [WORD_W-1:0]   host_rdata,
    input  logic                rx_commit,
    input  logic [BUF_BITS-1:0] rx_data,
    input  logic                sta_commit,
    input  logic [STA_W-1:0]    sta_data,
    input  logic [EV_N-1:0]     done_evt,
    output logic [BUF_BITS-1:0] tx_flat,
    output logic [STA_W-1:0]    status,
    output logic                edge_rise,
    output logic                irq
);
    localparam int STA_REG  = 2 * BUF_WORDS;
    localparam int FLG_REG  = STA_REG + 1;
    localparam int CTL_REG  = STA_REG + 2;
    localparam int EDGE_BIT = 8;

    typedef struct packed {
        logic [BUF_WORDS-1:0][WORD_W-1:0] rx;
        logic [BUF_WORDS-1:0][WORD_W-1:0] tx;
        logic [STA_W-1:0]                 sta;
        logic [EV_N-1:0]                  flg;
        logic [EV_N-1:0]                  en;
        logic                             erise;
    } rg_t;
    rg_t r_q, r_d;
    logic [EV_N-1:0] clr;

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (host_we) begin
            for (int i = 0; i < BUF_WORDS; i++)
                if (host_addr == REG_AW'(BUF_WORDS + i)) r_d.tx[i] = host_wdata;
            if (host_addr == REG_AW'(STA_REG)) r_d.sta = host_wdata[STA_W-1:0];
            if (host_addr == REG_AW'(FLG_REG)) clr = host_wdata[EV_N-1:0];
            if (host_addr == REG_AW'(CTL_REG)) begin
                r_d.en    = host_wdata[EV_N-1:0];
                r_d.erise = host_wdata[EDGE_BIT];
            end
        end
        r_d.flg = (r_q.flg & ~clr) | done_evt;
        if (rx_commit)
            for (int i = 0; i < BUF_WORDS; i++)
                r_d.rx[i] = rx_data[BUF_BITS-1-i*WORD_W -: WORD_W];
        if (sta_commit) r_d.sta = sta_data;

        host_rdata = '0;
        for (int i = 0; i < BUF_WORDS; i++) begin
            if (host_addr == REG_AW'(i))             host_rdata = r_q.rx[i];
            if (host_addr == REG_AW'(BUF_WORDS + i)) host_rdata = r_q.tx[i];
        end
        if (host_addr == REG_AW'(STA_REG)) host_rdata[STA_W-1:0] = r_q.sta;
        if (host_addr == REG_AW'(FLG_REG)) host_rdata[EV_N-1:0]  = r_q.flg;
        if (host_addr == REG_AW'(CTL_REG)) begin
            host_rdata[EV_N-1:0]   = r_q.en;
            host_rdata[EDGE_BIT]   = r_q.erise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_flat   = r_q.tx;
    assign status    = r_q.sta;
    assign edge_rise = r_q.erise;
    assign irq       = |(r_q.flg & r_q.en);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == REG_AW'(FLG_REG) && done_evt == '0)
        |=> ((r_q.flg & $past(host_wdata[EV_N-1:0])) == '0));

    // R5
    trans_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt[EV_TRANS] |=> r_q.flg[EV_TRANS]);

    // R6
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en == '0) |-> !irq);
endmodule

// File: rtl/spis_cmdbuf.sv
`timescale 1ns/1ps
module spis_cmdbuf import spis_pkg::*; #(
    parameter int BUF_WORDS = 8,
    parameter int WORD_W    = 32,
    parameter int STA_W     = 8,
    parameter int ADDR_W    = 8,
    localparam int BUF_BITS = BUF_WORDS * WORD_W,
    localparam int REG_AW   = $clog2(2 * BUF_WORDS + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              irq
);
    logic [2:0]          pins_s;
    logic                rx_commit, sta_commit, edge_rise;
    logic [BUF_BITS-1:0] rx_data, tx_flat;
    logic [STA_W-1:0]    sta_data, status;
    logic [EV_N-1:0]     done_evt;

    spis_sync #(.W(3), .INIT(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, mosi}), .q(pins_s)
    );

    spis_frame #(.BUF_BITS(BUF_BITS), .STA_W(STA_W), .ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[0]),
        .edge_rise(edge_rise), .tx_flat(tx_flat), .status(status),
        .miso(miso), .rx_commit(rx_commit), .rx_data(rx_data),
        .sta_commit(sta_commit), .sta_data(sta_data), .done_evt(done_evt)
    );

    spis_regs #(.BUF_WORDS(BUF_WORDS), .WORD_W(WORD_W), .STA_W(STA_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_commit(rx_commit), .rx_data(rx_data),
        .sta_commit(sta_commit), .sta_data(sta_data), .done_evt(done_evt),
        .tx_flat(tx_flat), .status(status), .edge_rise(edge_rise), .irq(irq)
    );
endmodule

// File: tb/spis_cmdbuf_test.sv
`timescale 1ns/1ps
module spis_cmdbuf_test;
    localparam time HALF = 40ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso, irq;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit mode_rise = 0;
    logic [255:0] pay, got;
    logic hdr_hot;
    logic [31:0] exp_rx [8];
    logic [31:0] txw [8];

    always #2.5 clk = ~clk;

    spis_cmdbuf uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hw(input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input int a, output logic [31:0] d);
        @(negedge clk);
        host_addr = 5'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        if (mode_rise) begin
            mosi = b; #HALF; r = miso; sclk = 1'b1; #HALF; sclk = 1'b0;
        end else begin
            sclk = 1'b1; mosi = b; #HALF; r = miso; sclk = 1'b0; #HALF;
        end
    endtask

    task automatic frame(input logic [7:0] c, input logic [7:0] a, input int nb);
        logic r;
        got = '0; hdr_hot = 1'b0;
        cs_n = 1'b0; #HALF;
        for (int k = 0; k < 8; k++) begin bit_xfer(c[7-k], r); if (r) hdr_hot = 1'b1; end
        for (int k = 0; k < 8; k++) begin bit_xfer(a[7-k], r); if (r) hdr_hot = 1'b1; end
        for (int k = 0; k < nb; k++) begin bit_xfer(pay[255-k], r); got[255-k] = r; end
        #HALF; cs_n = 1'b1; mosi = 1'b0;
        repeat (20) @(posedge clk);
    endtask

    function automatic logic [255:0] mk_pay(input int seed);
        logic [255:0] v;
        for (int k = 0; k < 32; k++) v[255-8*k -: 8] = 8'((seed * 61 + k * 7 + 3) & 255);
        return v;
    endfunction

    task automatic check_rx(input string req);
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin hr(i, d); chk(req, d, exp_rx[i]); end
    endtask

    task automatic check_flags(input string req, input logic [31:0] exp);
        logic [31:0] d;
        hr(17, d); chk(req, d, exp);
    endtask

    initial begin
        #900us;
        if (!finished) begin
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 8; i++) exp_rx[i] = '0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R1 reset state
        for (int a = 0; a < 19; a++) begin hr(a, d); chk("R1 reg", d, 32'h0); end
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 miso", 32'(miso), 32'h0);

        // R2 R8 R11 R5 R6 R7: write frames in both sample-edge modes
        for (int m = 0; m < 2; m++) begin
            mode_rise = (m == 1);
            hw(18, {23'h0, mode_rise, 3'h0, 5'h1F});
            for (int s = 0; s < 3; s++) begin
                pay = mk_pay(s + 4 * m);
                frame(8'h02, 8'(s * 8'h55), 256);
                for (int i = 0; i < 8; i++) exp_rx[i] = pay[255-32*i -: 32];
                check_rx("R2 R8 R11 rx word");
                check_flags("R5 write flags", 32'h11);
                chk("R6 irq set", 32'(irq), 32'h1);
                hw(17, 32'h1F);
                check_flags("R7 cleared", 32'h0);
                chk("R6 irq clear", 32'(irq), 32'h0);
                chk("R12 miso idle", 32'(miso), 32'h0);
            end
        end

        // R3 read buffer (rising mode still set)
        for (int i = 0; i < 8; i++) begin
            txw[i] = 32'(i * 32'h1111_1111) ^ 32'hA5C3_0F96;
            hw(8 + i, txw[i]);
        end
        for (int i = 0; i < 8; i++) begin hr(8 + i, d); chk("R3 tx readback", d, txw[i]); end
        pay = '0;
        frame(8'h03, 8'h00, 256);
        for (int k = 0; k < 32; k++)
            chk("R3 byte out", 32'(got[255-8*k -: 8]), 32'(txw[k/4][8*(k%4) +: 8]));
        chk("R12 header miso", 32'(hdr_hot), 32'h0);
        check_rx("R3 rx kept");
        check_flags("R5 read flags", 32'h12);
        hw(17, 32'h1F);

        // R4 status write then read, falling mode
        mode_rise = 1'b0;
        hw(18, 32'h0000_001F);
        pay = '0; pay[255 -: 8] = 8'hA5;
        frame(8'h01, 8'h00, 8);
        hr(16, d); chk("R4 status write", d, 32'hA5);
        check_flags("R5 wsta flags", 32'h14);
        hw(17, 32'h1F);
        hw(16, 32'h3C);
        pay = '0;
        frame(8'h04, 8'h33, 8);
        chk("R4 status read", 32'(got[255 -: 8]), 32'h3C);
        check_flags("R5 rsta flags", 32'h18);
        hw(17, 32'h1F);

        // R6 enable masking
        hw(18, 32'h0000_0002);
        pay = mk_pay(20);
        frame(8'h02, 8'h00, 256);
        for (int i = 0; i < 8; i++) exp_rx[i] = pay[255-32*i -: 32];
        check_flags("R6 flags set", 32'h11);
        chk("R6 irq masked", 32'(irq), 32'h0);
        hw(18, 32'h0000_0001);
        chk("R6 irq unmasked", 32'(irq), 32'h1);
        hw(17, 32'h1F);
        hw(18, 32'h0000_001F);

        // R9 truncated frame, then a full frame
        pay = mk_pay(9);
        frame(8'h02, 8'h00, 100);
        check_flags("R9 no flag", 32'h0);
        check_rx("R9 no commit");
        frame(8'h01, 8'h00, 3);
        hr(16, d); chk("R9 status kept", d, 32'h3C);
        check_flags("R9 no flag sta", 32'h0);
        frame(8'h02, 8'h00, 256);
        for (int i = 0; i < 8; i++) exp_rx[i] = pay[255-32*i -: 32];
        check_rx("R9 next frame");
        check_flags("R9 next flags", 32'h11);
        hw(17, 32'h1F);

        // R10 unknown opcodes
        for (int c = 5; c < 8; c++) begin
            pay = {256{1'b1}};
            frame(8'(c), 8'h00, 256);
            chk("R10 miso low", 32'(|got | hdr_hot), 32'h0);
            check_flags("R10 no flag", 32'h0);
        end
        check_rx("R10 rx kept");
        hr(16, d); chk("R10 status kept", d, 32'h3C);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule